// File: doc/BRIEF.md
# Descriptor List Walker for a Packet DMA Channel

This block follows a list of transfer descriptors kept in memory for a single direction of a packet DMA channel. A start pulse loads the list origin. The walker then reads four words of the descriptor at that address over a burst-capable memory port. The burst sizes respect a programmable limit. The walker decodes the descriptor and hands each non-empty buffer, with its address, length and end-of-frame marker, to a downstream data mover through a valid/ready handshake.

After the buffers are handed over, the walker writes word 0 of the descriptor back. The write clears the ownership bit and places the mover's frame status in the low byte. The walker then picks the next descriptor. It can step by a fixed stride, wrap to the list origin, or follow an explicit pointer. When it meets a descriptor that software still owns, it halts and flags itself suspended until a poll pulse asks it to fetch that descriptor again.

A parameter selects the transmit or receive variant, which places the chaining and ring-end flags differently in word 0. The memory port takes one-cycle commands with a beat count. Read data and write acknowledgements both return on a shared valid strobe.

Top module: `dlw_top`

## Requirements
- R1: While reset is held and directly after it, `mem_req`, `buf_valid` and `suspended` are all low.
- R2: A `run` pulse, accepted while idle or suspended, latches `list_base` and starts a fetch of the descriptor at that address. `poll_demand` pulses seen while not suspended have no effect.
- R3: A descriptor fetch reads word offsets 0, 4, 8 and 12 in order. Each read command asks for min(limit, words still needed) beats, where a limit of 0 counts as 1. Every command lasts exactly one cycle.
- R4: If bit 31 of word 0 (ownership, 1 = walker) is 0, the walker issues no buffer and no write, raises `suspended`, and holds there. A `poll_demand` pulse in that state re-fetches the same descriptor address.
- R5: Word 1 carries length 1 in bits 12:0 and length 2 in bits 28:16. Word 2 is buffer address 1 and word 3 is buffer address 2. Without chaining, buffer 1 is offered before buffer 2.
- R6: The chain flag is bit 20 of word 0 for transmit (IS_TX=1) and bit 14 for receive. When it is set, word 3 is the next descriptor address, length 2 is ignored and only buffer 1 is offered.
- R7: Without chaining, the next descriptor sits at the current address plus DESC_BYTES. The ring-end flag (bit 21 for transmit, bit 15 for receive) sends the walker back to the latched list origin instead.
- R8: A buffer whose length field is zero produces no buffer request.
- R9: `buf_eof` is high only on the last buffer offered from a descriptor whose bit 29 of word 0 is set.
- R10: After its buffers are accepted, the descriptor's word 0 is written back at the descriptor address with bit 31 cleared and bits 7:0 replaced by `frame_status`. Bits 30:8 are kept.
- R11: While `buf_valid` is high and `buf_ready` is low, `buf_valid`, `buf_addr` and `buf_len` remain unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| list_base | input | AW | Byte address of the first descriptor |
| run | input | 1 | Start pulse: latch list_base and fetch |
| poll_demand | input | 1 | Re-fetch pulse while suspended |
| burst_limit | input | LIMW | Maximum beats per read command |
| frame_status | input | 8 | Status byte merged into the write-back |
| mem_req | output | 1 | One-cycle memory command |
| mem_we | output | 1 | Command is a write |
| mem_addr | output | AW | Command byte address |
| mem_blen | output | LIMW | Beats in the command |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read beat or write acknowledge |
| mem_rdata | input | 32 | Read beat data |
| buf_valid | output | 1 | Buffer request valid |
| buf_ready | input | 1 | Data mover accepts the request |
| buf_addr | output | AW | Buffer byte address |
| buf_len | output | 13 | Buffer length in bytes |
| buf_eof | output | 1 | Buffer closes a frame |
| suspended | output | 1 | Halted on a software-owned descriptor |

## Verification
On every cycle, the assertions check the following:
- read commands are one-cycle pulses that never overrun the four descriptor words;
- a stalled buffer request holds still;
- no zero-length buffer is ever offered;
- the suspended state stays silent on both ports;
- a poll pulse always leaves the suspended state.

Only the bench scenarios can show the rest:
- the order and addresses of the fetch bursts under limits of 4, 3 and 1;
- the sequential step, the ring wrap and the chained pointer;
- the skipping of empty buffers;
- the end-of-frame placement;
- the exact word written back to memory.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
   localparam int WORD_W      = 32;
   localparam int FETCH_WORDS = 4;
   localparam int LEN_W       = 13;
   localparam int OWN_POS     = 31;
   localparam int EOF_POS     = 29;
   localparam int STAT_W      = 8;

   typedef struct packed {
      logic              own;
      logic              chain;
      logic              ring_end;
      logic              eof;
      logic [LEN_W-1:0]  len1;
      logic [LEN_W-1:0]  len2;
      logic [WORD_W-1:0] addr1;
      logic [WORD_W-1:0] addr2;
   } desc_t;

   typedef enum logic [3:0] {
      S_IDLE, S_LAUNCH, S_FETCH, S_DEC, S_BUF1, S_BUF2, S_WB, S_WBW, S_SUSP
   } walk_st_e;
endpackage

// File: rtl/dlw_fetch.sv
module dlw_fetch
   import dlw_pkg::*;
#(
   parameter int AW   = 32,
   parameter int LIMW = 5
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                go,
   input  logic [AW-1:0]                       desc_addr,
   input  logic [LIMW-1:0]                     limit,
   output logic                                cmd_valid,
   output logic [AW-1:0]                       cmd_addr,
   output logic [LIMW-1:0]                     cmd_blen,
   input  logic                                rvalid,
   input  logic [WORD_W-1:0]                   rdata,
   output logic [FETCH_WORDS-1:0][WORD_W-1:0]  words,
   output logic                                done
);
   localparam int IDXW = $clog2(FETCH_WORDS) + 1;

   typedef enum logic [1:0] {F_IDLE, F_CMD, F_DATA} f_st_e;

   f_st_e           st;
   logic [IDXW-1:0] widx;
   logic [LIMW-1:0] beats;
   logic [AW-1:0]   base_q;
   logic [LIMW-1:0] lim_eff;
   logic [LIMW-1:0] remaining;

   assign lim_eff   = (limit == '0) ? LIMW'(1) : limit;
   assign remaining = LIMW'(FETCH_WORDS) - LIMW'(widx);
   assign cmd_blen  = (lim_eff < remaining) ? lim_eff : remaining;
   assign cmd_valid = (st == F_CMD);
   assign cmd_addr  = base_q + AW'({widx, 2'b00});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= F_IDLE;
         widx   <= '0;
         beats  <= '0;
         base_q <= '0;
         words  <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            F_IDLE: if (go) begin
               base_q <= desc_addr;
               widx   <= '0;
               st     <= F_CMD;
            end
            F_CMD: begin
               beats <= cmd_blen;
               st    <= F_DATA;
            end
            F_DATA: if (rvalid) begin
               words[widx[IDXW-2:0]] <= rdata;
               widx  <= widx + 1'b1;
               beats <= beats - 1'b1;
               if (beats == LIMW'(1)) begin
                  if (widx == IDXW'(FETCH_WORDS - 1)) begin
                     st   <= F_IDLE;
                     done <= 1'b1;
                  end else begin
                     st <= F_CMD;
                  end
               end
            end
            default: st <= F_IDLE;
         endcase
      end
   end

   // R3: a read command is a single-cycle pulse
   p_cmd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   // R3: no command starts beyond the last descriptor word
   p_cmd_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (widx < IDXW'(FETCH_WORDS)));
endmodule

// File: rtl/dlw_decode.sv
module dlw_decode
   import dlw_pkg::*;
#(
   parameter bit IS_TX = 1'b1
) (
   input  logic [FETCH_WORDS-1:0][WORD_W-1:0] words,
   output desc_t                              d
);
   localparam int CHAIN_POS = IS_TX ? 20 : 14;
   localparam int RING_POS  = CHAIN_POS + 1;

   logic unused_bits;

   generate
      if (IS_TX) begin : g_tx
         assign d.chain    = words[0][CHAIN_POS];
         assign d.ring_end = words[0][RING_POS];
      end else begin : g_rx
         assign d.chain    = words[0][CHAIN_POS];
         assign d.ring_end = words[0][RING_POS];
      end
   endgenerate

   assign d.own   = words[0][OWN_POS];
   assign d.eof   = words[0][EOF_POS];
   assign d.len1  = words[1][LEN_W-1:0];
   assign d.len2  = words[1][16 +: LEN_W];
   assign d.addr1 = words[2];
   assign d.addr2 = words[3];

   assign unused_bits = ^{words[0], words[1][31:29], words[1][15:13]};
endmodule

// File: rtl/dlw_top.sv
module dlw_top
   import dlw_pkg::*;
#(
   parameter int AW         = 32,
   parameter int LIMW       = 5,
   parameter int DESC_BYTES = 32,
   parameter bit IS_TX      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     list_base,
   input  logic              run,
   input  logic              poll_demand,
   input  logic [LIMW-1:0]   burst_limit,
   input  logic [STAT_W-1:0] frame_status,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [LIMW-1:0]   mem_blen,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_rvalid,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              buf_valid,
   input  logic              buf_ready,
   output logic [AW-1:0]     buf_addr,
   output logic [LEN_W-1:0]  buf_len,
   output logic              buf_eof,
   output logic              suspended
);
   generate
      if (DESC_BYTES < FETCH_WORDS * 4) begin : g_bad_stride
         $error("DESC_BYTES must cover the fetched words");
      end
      if (AW < 8 || AW > WORD_W) begin : g_bad_aw
         $error("AW out of range");
      end
      if (LIMW < 3) begin : g_bad_limw
         $error("LIMW too narrow for a full descriptor burst");
      end
   endgenerate

   walk_st_e                          st;
   logic [AW-1:0]                     cur;
   logic [AW-1:0]                     base_q;
   logic [AW-1:0]                     nxt;
   logic [FETCH_WORDS-1:0][WORD_W-1:0] words;
   desc_t                             d;
   logic                              f_go, f_cmd, f_done, has2;
   logic [AW-1:0]                     f_addr;
   logic [LIMW-1:0]                   f_blen;
   logic                              unused_bits;

   dlw_fetch #(.AW(AW), .LIMW(LIMW)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (f_go),
      .desc_addr (cur),
      .limit     (burst_limit),
      .cmd_valid (f_cmd),
      .cmd_addr  (f_addr),
      .cmd_blen  (f_blen),
      .rvalid    (mem_rvalid),
      .rdata     (mem_rdata),
      .words     (words),
      .done      (f_done)
   );

   dlw_decode #(.IS_TX(IS_TX)) u_decode (
      .words (words),
      .d     (d)
   );

   assign f_go = (st == S_LAUNCH);
   assign has2 = !d.chain && (d.len2 != '0);
   assign nxt  = d.chain    ? d.addr2[AW-1:0] :
                 d.ring_end ? base_q : cur + AW'(DESC_BYTES);

   assign mem_req   = f_cmd || (st == S_WB);
   assign mem_we    = (st == S_WB);
   assign mem_addr  = (st == S_WB) ? cur : f_addr;
   assign mem_blen  = (st == S_WB) ? LIMW'(1) : f_blen;
   assign mem_wdata = {1'b0, words[0][OWN_POS-1:STAT_W], frame_status};

   assign buf_valid = (st == S_BUF1) || (st == S_BUF2);
   assign buf_addr  = (st == S_BUF2) ? d.addr2[AW-1:0] : d.addr1[AW-1:0];
   assign buf_len   = (st == S_BUF2) ? d.len2 : d.len1;
   assign buf_eof   = buf_valid && d.eof && ((st == S_BUF2) || !has2);
   assign suspended = (st == S_SUSP);

   assign unused_bits = ^{words[0][OWN_POS], words[0][STAT_W-1:0],
                          words[3:1], d.addr1, d.addr2};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         cur    <= '0;
         base_q <= '0;
      end else begin
         case (st)
            S_IDLE: if (run) begin
               cur    <= list_base;
               base_q <= list_base;
               st     <= S_LAUNCH;
            end
            S_LAUNCH: st <= S_FETCH;
            S_FETCH:  if (f_done) st <= S_DEC;
            S_DEC: begin
               if (!d.own)              st <= S_SUSP;
               else if (d.len1 != '0)   st <= S_BUF1;
               else if (has2)           st <= S_BUF2;
               else                     st <= S_WB;
            end
            S_BUF1: if (buf_ready) st <= has2 ? S_BUF2 : S_WB;
            S_BUF2: if (buf_ready) st <= S_WB;
            S_WB:   st <= S_WBW;
            S_WBW:  if (mem_rvalid) begin
               cur <= nxt;
               st  <= S_LAUNCH;
            end
            S_SUSP: begin
               if (run) begin
                  cur    <= list_base;
                  base_q <= list_base;
                  st     <= S_LAUNCH;
               end else if (poll_demand) begin
                  st <= S_LAUNCH;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R4: a halted walker is silent on both ports
   p_susp_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      suspended |-> (!buf_valid && !mem_req));

   // R4: a poll pulse always ends the suspension
   p_poll_resume_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (suspended && poll_demand) |=> !suspended);

   // R8: empty buffers never reach the data mover
   p_buf_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      buf_valid |-> (buf_len != '0));

   // R11: a stalled request keeps its contents
   p_buf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_valid && !buf_ready) |=> (buf_valid && $stable(buf_addr) && $stable(buf_len)));
endmodule

// File: tb/dlw_top_bench.sv
`timescale 1ns/1ps
module dlw_top_bench;
   localparam int AW   = 32;
   localparam int LIMW = 5;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [AW-1:0]   list_base;
   logic            run, poll_demand;
   logic [LIMW-1:0] burst_limit;
   logic [7:0]      frame_status;
   logic            mem_req, mem_we;
   logic [AW-1:0]   mem_addr;
   logic [LIMW-1:0] mem_blen;
   logic [31:0]     mem_wdata;
   logic            mem_rvalid = 1'b0;
   logic [31:0]     mem_rdata = '0;
   logic            buf_valid;
   logic            buf_ready = 1'b0;
   logic [AW-1:0]   buf_addr;
   logic [12:0]     buf_len;
   logic            buf_eof;
   logic            suspended;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [31:0] mem [128];

   logic [31:0] bq_addr [$];
   int          bq_len  [$];
   bit          bq_eof  [$];
   logic [31:0] fq_addr [$];
   int          fq_blen [$];

   dlw_top #(.AW(AW), .LIMW(LIMW), .DESC_BYTES(32), .IS_TX(1'b1)) u_dlw_top (
      .clk, .rst_n, .list_base, .run, .poll_demand, .burst_limit, .frame_status,
      .mem_req, .mem_we, .mem_addr, .mem_blen, .mem_wdata, .mem_rvalid, .mem_rdata,
      .buf_valid, .buf_ready, .buf_addr, .buf_len, .buf_eof, .suspended
   );

   always #5 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic push_buf(input logic [31:0] a, input int l, input bit e);
      bq_addr.push_back(a);
      bq_len.push_back(l);
      bq_eof.push_back(e);
   endtask

   task automatic push_fetch(input logic [31:0] a, input int lim);
      int got = 0;
      int l = (lim == 0) ? 1 : lim;
      while (got < 4) begin
         int b = (l < 4 - got) ? l : 4 - got;
         fq_addr.push_back(a + 32'(4 * got));
         fq_blen.push_back(b);
         got += b;
      end
   endtask

   task automatic wait_susp(input string tag);
      int n = 0;
      repeat (4) @(negedge clk);
      while (!suspended && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk(tag, 32'(suspended), 32'd1);
   endtask

   // data mover handshake pattern
   int rcnt = 0;
   always @(posedge clk) begin
      #2;
      rcnt++;
      buf_ready = (rcnt % 3) != 0;
   end

   // memory model and fetch scoreboard
   int          pend = 0;
   logic [31:0] pa = '0;
   bit          pw = 1'b0;
   always @(negedge clk) begin
      if (pend > 0) begin
         mem_rvalid = 1'b1;
         mem_rdata  = pw ? 32'h0 : mem[pa[8:2]];
         pa  += 4;
         pend--;
      end else begin
         mem_rvalid = 1'b0;
      end
      if (rst_n && mem_req) begin
         if (mem_we) begin
            mem[mem_addr[8:2]] = mem_wdata;
            pend = 1;
            pw   = 1'b1;
         end else begin
            if (fq_addr.size() == 0) begin
               checks++;
               errors++;
               $display("FAIL R2 R4 unexpected fetch: actual %h expected none", mem_addr);
            end else begin
               chk("R2 R3 R6 R7 fetch address", mem_addr, fq_addr.pop_front());
               chk("R3 burst length", 32'(mem_blen), 32'(fq_blen.pop_front()));
            end
            pend = int'(mem_blen);
            pa   = mem_addr;
            pw   = 1'b0;
         end
      end
   end

   // buffer scoreboard
   always @(negedge clk) begin
      if (rst_n && buf_valid && buf_ready) begin
         if (bq_addr.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R6 R8 unexpected buffer: actual %h expected none", buf_addr);
         end else begin
            chk("R5 R6 buffer address", buf_addr, bq_addr.pop_front());
            chk("R5 R8 buffer length", 32'(buf_len), 32'(bq_len.pop_front()));
            chk("R9 end of frame", 32'(buf_eof), 32'(bq_eof.pop_front()));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; run = 1'b0; poll_demand = 1'b0;
      list_base = '0; burst_limit = 5'd4; frame_status = 8'hA5;
      for (int i = 0; i < 128; i++) mem[i] = '0;
      // scenario A: two buffers, empty buffer skip, ring wrap
      mem[0] = 32'h8000_12FF; mem[1] = 32'h0032_0064; mem[2] = 32'h1000; mem[3] = 32'h2000;
      mem[8] = 32'hA020_0000; mem[9] = 32'h003C_0000; mem[10] = 32'h5555; mem[11] = 32'h3000;
      repeat (3) @(negedge clk);
      chk("R1 mem_req in reset", 32'(mem_req), 32'd0);
      chk("R1 buf_valid in reset", 32'(buf_valid), 32'd0);
      chk("R1 suspended in reset", 32'(suspended), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", 32'(mem_req | buf_valid | suspended), 32'd0);
      poll_demand = 1'b1;                       // R2: ignored while idle
      @(negedge clk);
      poll_demand = 1'b0;
      repeat (5) @(negedge clk);
      chk("R2 poll ignored when idle", 32'(mem_req | suspended), 32'd0);

      push_buf(32'h1000, 100, 1'b0);
      push_buf(32'h2000, 50, 1'b0);
      push_buf(32'h3000, 60, 1'b1);            // R8 len1 zero skipped
      push_fetch(32'h00, 4); push_fetch(32'h20, 4); push_fetch(32'h00, 4);
      list_base = 32'h0; run = 1'b1;
      @(negedge clk);
      run = 1'b0;
      wait_susp("R4 suspend on owned descriptor");
      chk("R10 write-back desc 0", mem[0], 32'h0000_12A5);
      chk("R10 write-back desc 1", mem[8], 32'h2020_00A5);
      chk("R5 R7 scenario A drained", 32'(bq_addr.size() + fq_addr.size()), 32'd0);
      repeat (20) @(negedge clk);
      chk("R4 stays suspended", 32'(suspended), 32'd1);

      // scenario B: chained list, poll restart, burst limit 3
      burst_limit = 5'd3; frame_status = 8'h3C;
      mem[0]  = 32'hA010_0000; mem[1]  = 32'h0000_0010; mem[2]  = 32'h1100; mem[3]  = 32'h60;
      mem[24] = 32'hA010_0000; mem[25] = 32'h004D_0008; mem[26] = 32'h1200; mem[27] = 32'h40;
      push_buf(32'h1100, 16, 1'b1);
      push_buf(32'h1200, 8, 1'b1);             // R6 len2 of 77 not offered
      push_fetch(32'h00, 3); push_fetch(32'h60, 3); push_fetch(32'h40, 3);
      poll_demand = 1'b1;
      @(negedge clk);
      poll_demand = 1'b0;
      wait_susp("R4 suspend after chain");
      chk("R10 write-back chained head", mem[0], 32'h2010_003C);
      chk("R10 write-back chained second", mem[24], 32'h2010_003C);
      chk("R6 scenario B drained", 32'(bq_addr.size() + fq_addr.size()), 32'd0);

      // scenario C: both lengths zero, new origin, sequential step, limit 1
      burst_limit = 5'd1; frame_status = 8'h5A;
      mem[32] = 32'hA000_0000; mem[33] = 32'h0; mem[34] = 32'h1300; mem[35] = 32'h1400;
      push_fetch(32'h80, 1); push_fetch(32'hA0, 1);
      list_base = 32'h80; run = 1'b1;
      @(negedge clk);
      run = 1'b0;
      wait_susp("R2 R4 suspend after restart");
      chk("R10 write-back empty descriptor", mem[32], 32'h2000_005A);
      chk("R8 R7 scenario C drained", 32'(bq_addr.size() + fq_addr.size()), 32'd0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule